// File: doc/BRIEF.md
# Level-Tracking Interrupt Aggregator

The block gathers a set of level-sensitive interrupt request lines into a single interrupt output for a processor. Each line has a pending bit and an enable bit. A pending bit is set on the cycle its line goes from low to high and is cleared when the line drops. Software can also wipe every pending bit and every enable bit with one write. The output is asserted whenever a line is both pending and enabled.

Software uses a small 32-bit register port with a request valid, a write flag, an address and write data. The block answers each read with a registered data word and a one-cycle valid pulse. Enable bits are changed through two registers: writing a 1 to a bit of one register sets that enable, and writing a 1 to a bit of the other clears it, so no read-modify-write is needed. Reads return either the number of active lines (pending and enabled) or their bit mask. Each line also has a rising-edge counter for statistics, which is read combinationally through a separate debug select port.

Top module: `irqc_top`

## Requirements
- R1: After reset, `irq_out` is 0, both readable registers return 0 and every statistics counter reads 0.
- R2: A line's pending bit is set on the clock edge at which the line is first sampled high after being low. It is cleared on the edge at which the line is sampled low.
- R3: A write to offset 0x10 sets every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to offset 0x0C clears every enable bit whose write-data bit is 1 and leaves the other enable bits unchanged.
- R5: A write of any value to offset 0x08 clears all enable bits and all pending bits. A line that stays high afterwards does not become pending again until it falls and rises.
- R6: If a line rises in the same cycle as a write to offset 0x08, its pending bit ends set.
- R7: A read of offset 0x00 returns the number of lines that are both pending and enabled, from 0 up to the line count.
- R8: A read of offset 0x04 returns the pending bits ANDed with the enable bits, with line i at bit i. It never returns the raw pending vector.
- R9: `irq_out` is 1 exactly when at least one line is both pending and enabled. It follows input changes and register writes on the same edge at which they update that state.
- R10: The statistics counter of a line increments once for each rising edge of that line and does not increment while the line is held high. `dbg_count` shows the counter of the line selected by `dbg_sel`.
- R11: Reads of any offset other than 0x00 and 0x04 return 0, including the write-only offsets and unaligned addresses. Writes to any offset other than 0x08, 0x0C and 0x10 have no effect.
- R12: Each accepted read produces exactly one `rsp_valid` pulse, one cycle later, and back-to-back reads produce back-to-back responses. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | NUM_LINES | Level-sensitive interrupt request lines |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined interrupt request |
| dbg_sel | input | $clog2(NUM_LINES) | Statistics line select |
| dbg_count | output | CNT_W | Rising-edge count of the selected line |

## Verification
Lines are raised and lowered one at a time, then two at a time with overlapping enables, then all at once. The single-line case separates set masking from clear masking. The overlapping case shows that set and clear writes only touch the bits written as 1, and the all-lines burst shows the count reaching its maximum. A wipe write is issued both while lines are held high and in the same cycle as a fresh rising edge, which separates the edge-driven set from the level of the line. The edge counters are read after that history, so a counter that counts cycles spent high, rather than rising edges, gives a wrong total.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned OFS_COUNT  = 'h00;
  localparam int unsigned OFS_MASK   = 'h04;
  localparam int unsigned OFS_WIPE   = 'h08;
  localparam int unsigned OFS_EN_CLR = 'h0C;
  localparam int unsigned OFS_EN_SET = 'h10;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_WIPE   = 2'd1,
    WR_EN_CLR = 2'd2,
    WR_EN_SET = 2'd3
  } wr_op_e;

  typedef enum logic [1:0] {
    RD_ZERO  = 2'd0,
    RD_COUNT = 2'd1,
    RD_MASK  = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output wr_op_e            wr_op,
  output rd_sel_e           rd_sel,
  output logic              rd_req
);
  always_comb begin
    wr_op  = WR_NONE;
    rd_sel = RD_ZERO;
    rd_req = req_valid && !req_write;
    if (req_valid && req_write) begin
      if (req_addr == ADDR_W'(OFS_WIPE))        wr_op = WR_WIPE;
      else if (req_addr == ADDR_W'(OFS_EN_CLR)) wr_op = WR_EN_CLR;
      else if (req_addr == ADDR_W'(OFS_EN_SET)) wr_op = WR_EN_SET;
    end
    if (rd_req) begin
      if (req_addr == ADDR_W'(OFS_COUNT))     rd_sel = RD_COUNT;
      else if (req_addr == ADDR_W'(OFS_MASK)) rd_sel = RD_MASK;
    end
  end
endmodule

// File: rtl/irqc_lines.sv
module irqc_lines
  import irqc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  wr_op_e       wr_op,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] pending,
  output logic [N-1:0] enabled,
  output logic [N-1:0] level_q,
  output logic [N-1:0] rise,
  output logic         irq_out
);
  logic [N-1:0] fall, pend_nx, en_nx;
  logic         pend_ld, en_ld, lvl_ld;

  always_comb begin
    rise    = irq_in & ~level_q;
    fall    = ~irq_in & level_q;
    lvl_ld  = |(rise | fall);
    pend_nx = pending;
    if (wr_op == WR_WIPE) pend_nx = '0;
    pend_nx = (pend_nx & ~fall) | rise;
    pend_ld = lvl_ld || (wr_op == WR_WIPE);
    en_nx   = enabled;
    unique case (wr_op)
      WR_WIPE:   en_nx = '0;
      WR_EN_CLR: en_nx = enabled & ~wbits;
      WR_EN_SET: en_nx = enabled | wbits;
      default:   en_nx = enabled;
    endcase
    en_ld   = (wr_op != WR_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enabled <= '0;
      level_q <= '0;
    end else begin
      if (pend_ld) pending <= pend_nx;
      if (en_ld)   enabled <= en_nx;
      if (lvl_ld)  level_q <= irq_in;
    end
  end

  assign irq_out = |(pending & enabled);
endmodule

// File: rtl/irqc_stats.sv
module irqc_stats #(
  parameter int N     = 32,
  parameter int CNT_W = 32,
  parameter int SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     rise,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q [N];

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [CNT_W-1:0] cnt_nx;
    assign cnt_nx = cnt_q[i] + CNT_W'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q[i] <= '0;
      else if (rise[i]) cnt_q[i] <= cnt_nx;
    end
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++)
      if (sel == SEL_W'(i)) count = cnt_q[i];
  end
endmodule

// File: rtl/irqc_rdport.sv
module irqc_rdport
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int POP_W  = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  rd_sel_e           rd_sel,
  input  logic [N-1:0]      active,
  output logic [POP_W-1:0]  pop_cnt,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [DATA_W-1:0] rdata_nx;

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < N; i++) pop_cnt = pop_cnt + POP_W'(active[i]);
    unique case (rd_sel)
      RD_COUNT: rdata_nx = DATA_W'(pop_cnt);
      RD_MASK:  rdata_nx = DATA_W'(active);
      default:  rdata_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rdata_nx;
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LINES-1:0]         irq_in,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata,
  output logic                         irq_out,
  input  logic [$clog2(NUM_LINES)-1:0] dbg_sel,
  output logic [CNT_W-1:0]             dbg_count
);
  localparam int SEL_W = $clog2(NUM_LINES);
  localparam int POP_W = $clog2(NUM_LINES + 1);

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  wr_op_e               wr_op;
  rd_sel_e              rd_sel;
  logic                 rd_req;
  logic [NUM_LINES-1:0] pending, enabled, level_q, rise;
  logic [POP_W-1:0]     pop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wr_op(wr_op), .rd_sel(rd_sel), .rd_req(rd_req)
  );

  irqc_lines #(.N(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_int_n), .irq_in(irq_in), .wr_op(wr_op),
    .wbits(req_wdata[NUM_LINES-1:0]), .pending(pending), .enabled(enabled),
    .level_q(level_q), .rise(rise), .irq_out(irq_out)
  );

  irqc_stats #(.N(NUM_LINES), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_stats (
    .clk(clk), .rst_n(rst_int_n), .rise(rise), .sel(dbg_sel), .count(dbg_count)
  );

  irqc_rdport #(.N(NUM_LINES), .DATA_W(DATA_W), .POP_W(POP_W)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .rd_req(rd_req), .rd_sel(rd_sel),
    .active(pending & enabled), .pop_cnt(pop_cnt),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int N      = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int POP_W  = $clog2(N + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              irq_out,
  input logic [N-1:0]      pending,
  input logic [N-1:0]      enabled,
  input logic [N-1:0]      level_q,
  input logic [POP_W-1:0]  pop_cnt
);
  a_r2_pend_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & ~level_q) == '0);

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(OFS_EN_SET)) |=>
      ((enabled & $past(req_wdata[N-1:0])) == $past(req_wdata[N-1:0])));

  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(OFS_EN_CLR)) |=>
      ((enabled & $past(req_wdata[N-1:0])) == '0));

  a_r5_wipe_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == ADDR_W'(OFS_WIPE)) |=> (enabled == '0));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    pop_cnt <= POP_W'(N));

  a_r9_out_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pop_cnt != '0));

  a_r12_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  a_r12_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind irqc_top irqc_chk #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .irq_out(irq_out), .pending(pending), .enabled(enabled), .level_q(level_q),
  .pop_cnt(pop_cnt)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_out;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_count;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_out(irq_out),
    .dbg_sel(dbg_sel), .dbg_count(dbg_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_lines(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic check_count(logic [4:0] line, logic [31:0] exp, string req);
    @(negedge clk);
    dbg_sel = line;
    #1;
    check(req, dbg_count, exp);
  endtask

  // Monitor: pops expected read data as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R12: actual=response expected=no response");
        end else begin
          check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'd0);
    bus_read(6'h00, 32'd0, "R1 count");
    bus_read(6'h04, 32'd0, "R1 mask");
    check_count(5'd0, 32'd0, "R1 counter line 0");
    check_count(5'd31, 32'd0, "R1 counter line 31");

    // lines 0 and 2 rise, nothing enabled
    set_lines(32'h5);
    check("R9 no enable", {31'b0, irq_out}, 32'd0);
    bus_read(6'h04, 32'd0, "R8 masked by enable");
    bus_write(6'h10, 32'h1);
    check("R9 enabled pending", {31'b0, irq_out}, 32'd1);
    bus_read(6'h04, 32'h1, "R3 set line 0");
    bus_read(6'h00, 32'd1, "R7 count one");
    bus_write(6'h10, 32'h4);
    bus_read(6'h04, 32'h5, "R3 set keeps others");
    bus_read(6'h00, 32'd2, "R7 count two");
    bus_write(6'h0C, 32'h1);
    bus_read(6'h04, 32'h4, "R4 clear line 0 only");

    // line 2 falls, then rises again
    set_lines(32'h1);
    check("R9 fall drops out", {31'b0, irq_out}, 32'd0);
    bus_read(6'h04, 32'h0, "R2 fall clears");
    set_lines(32'h5);
    bus_read(6'h04, 32'h4, "R2 rise sets");

    // wipe while lines held high
    bus_write(6'h08, 32'h0);
    check("R5 irq_out after wipe", {31'b0, irq_out}, 32'd0);
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_read(6'h04, 32'h0, "R5 held lines stay clear");

    // wipe in same cycle as line 3 rising
    @(negedge clk);
    irq_in = 32'hD;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'h08; req_wdata = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R5 wipe clears enables", {31'b0, irq_out}, 32'd0);
    bus_write(6'h10, 32'hFFFF_FFFF);
    bus_read(6'h04, 32'h8, "R6 rise wins over wipe");
    check("R9 after re-enable", {31'b0, irq_out}, 32'd1);

    // all lines at once
    set_lines(32'h0);
    set_lines(32'hFFFF_FFFF);
    bus_read(6'h00, 32'd32, "R7 count max");
    bus_read(6'h04, 32'hFFFF_FFFF, "R8 full mask");

    // unmapped accesses
    bus_read(6'h14, 32'h0, "R11 read unmapped");
    bus_read(6'h0C, 32'h0, "R11 read write-only");
    bus_read(6'h02, 32'h0, "R11 read unaligned");
    bus_write(6'h14, 32'h0);
    bus_write(6'h0E, 32'hFFFF_FFFF);
    bus_write(6'h09, 32'h0);
    bus_read(6'h04, 32'hFFFF_FFFF, "R11 writes ignored");

    // back-to-back reads
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h00;
    exp_q.push_back(32'd32); tag_q.push_back("R12 first of pair");
    @(negedge clk);
    req_addr = 6'h04;
    exp_q.push_back(32'hFFFF_FFFF); tag_q.push_back("R12 second of pair");
    @(negedge clk);
    req_valid = 1'b0;

    // edge counters
    check_count(5'd0, 32'd2, "R10 line 0");
    check_count(5'd1, 32'd1, "R10 line 1");
    check_count(5'd2, 32'd3, "R10 line 2");
    check_count(5'd3, 32'd2, "R10 line 3");
    check_count(5'd31, 32'd1, "R10 line 31");

    repeat (3) @(negedge clk);
    check("R12 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule